// File: doc/BRIEF.md
# Two-Speed Digital Gain Controller

This block closes the gain loop of a single receiver channel. It takes one signed converter sample per clock and keeps a running energy figure. From that figure and from overload detection it computes a gain code for an external variable-gain amplifier. Two loops share the gain register. The fast loop reacts to clipped samples and cuts the gain by a large step. A holdoff stops it from stepping again at once. The slow loop runs only when the fast loop is idle. Once per averaging period it nudges the gain by one unit toward a target energy band, and a dead band around the target stops it from hunting.

For diagnosis the block reports three figures. The first is the number of clipped samples in each measurement window. The second is the number of cycles the gain spent at its floor in that window. The third is the length of the most recent recovery, counted from the last clipped sample until the energy is back inside the target band. All settings arrive on plain parallel configuration inputs. The block does not close the loop through the amplifier: the gain code is an output only.

Top module: `agc_two_speed`

## Requirements
- R1: The energy accumulator updates every cycle as acc <= acc - (acc >> EST_SHIFT) + sample*sample, starting from 0. `energy_o` equals acc >> EST_SHIFT.
- R2: A sample is clipped when its magnitude is at least FULL_SCALE (default 2047, so both 2047 and -2048 clip). The clipped flag is registered and takes effect in the cycle after the sample is applied.
- R3: The fast step fires when the clipped flag is set and the holdoff counter is zero. It lowers the gain by `cfg_coarse_step_i`, flooring at `cfg_gain_min_i`, and loads the holdoff counter with `cfg_holdoff_i`. The gain does not change while the holdoff counter is non-zero.
- R4: The fast loop counts as active while the clipped flag is set or the holdoff counter is non-zero. While it is active the gain never rises, and the slow loop's period counter is held at zero.
- R5: When the fast loop is idle, the slow loop acts once every `cfg_period_i` cycles. If energy > target + deadband it lowers the gain by 1. If energy + deadband < target it raises the gain by 1. Otherwise the gain holds.
- R6: The gain saturates at `cfg_gain_min_i` and `cfg_gain_max_i` and never wraps.
- R7: Clipped samples are summed over a window of `cfg_window_i` cycles. On the window's last cycle the total, including that cycle, moves to `clip_count_o` and the running sum restarts from 0.
- R8: Cycles in which the gain equals `cfg_gain_min_i` are summed per window in the same way and published on `sat_time_o`.
- R9: A clipped cycle starts a recovery count at 1. The count then grows by 1 for each later cycle whose energy lies outside [target - deadband, target + deadband]. The first in-band cycle with no clip publishes the count on `desat_time_o`, and the value holds until the next recovery ends.
- R10: Under synchronous reset the gain loads `cfg_gain_max_i`, and the energy, counters and all diagnostic outputs clear to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_i | input | DATA_W | Signed converter sample, one per cycle |
| cfg_target_i | input | 2*DATA_W | Target energy |
| cfg_deadband_i | input | 2*DATA_W | Half-width of the target band |
| cfg_gain_min_i | input | GAIN_W | Gain floor |
| cfg_gain_max_i | input | GAIN_W | Gain ceiling and reset value |
| cfg_coarse_step_i | input | GAIN_W | Fast-loop step size |
| cfg_holdoff_i | input | HOLD_W | Cycles blocked after a fast step |
| cfg_period_i | input | PER_W | Slow-loop period in cycles (non-zero) |
| cfg_window_i | input | WIN_W | Measurement window length in cycles (non-zero) |
| gain_o | output | GAIN_W | Gain code to the amplifier |
| energy_o | output | 2*DATA_W | Energy estimate |
| clip_count_o | output | CNT_W | Clipped samples in the last closed window |
| sat_time_o | output | CNT_W | Cycles at the gain floor in the last closed window |
| desat_time_o | output | CNT_W | Length of the last completed recovery |

## Verification
The hardest state to reach is a completed recovery measurement. It needs a clip burst long enough to drive the gain to its floor through repeated holdoff-gated steps. It must then be followed by samples whose squared value sits inside the target band, and the leaky average has to decay from near full-scale energy into that band. The stimulus therefore runs in phases. It holds the gain at its ceiling with quiet input, pulls it down with strong input, drives it to the floor with alternating full-scale codes, and then waits through the in-band decay. A long random phase with sparse clips then mixes fast steps, holdoff windows and slow trims.

// File: rtl/agc_pkg.sv
package agc_pkg;
  typedef enum logic [1:0] {
    GSTEP_HOLD,
    GSTEP_UP,
    GSTEP_DOWN,
    GSTEP_COARSE
  } gstep_e;
endpackage

// File: rtl/agc_energy_est.sv
module agc_energy_est #(
  parameter  int DATA_W     = 12,
  parameter  int EST_SHIFT  = 4,
  parameter  int FULL_SCALE = 2047,
  localparam int EN_W       = 2 * DATA_W,
  localparam int ACC_W      = EN_W + EST_SHIFT
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [DATA_W-1:0] sample_i,
  output logic [EN_W-1:0]          energy_o,
  output logic                     clip_o
);
  logic [ACC_W-1:0]       acc_q;
  logic [ACC_W-1:0]       acc_d;
  logic signed [EN_W-1:0] sq_s;
  logic [DATA_W-1:0]      mag;

  always_comb begin
    sq_s  = sample_i * sample_i;
    mag   = sample_i[DATA_W-1] ? DATA_W'(-sample_i) : DATA_W'(sample_i);
    acc_d = acc_q - (acc_q >> EST_SHIFT) + ACC_W'(unsigned'(sq_s));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      clip_o <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      clip_o <= int'({1'b0, mag}) >= FULL_SCALE;
    end
  end

  assign energy_o = acc_q[ACC_W-1:EST_SHIFT];
endmodule

// File: rtl/agc_gain_ctrl.sv
module agc_gain_ctrl
  import agc_pkg::*;
#(
  parameter int EN_W   = 24,
  parameter int GAIN_W = 6,
  parameter int HOLD_W = 8,
  parameter int PER_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clip_i,
  input  logic [EN_W-1:0]   energy_i,
  input  logic [EN_W-1:0]   cfg_target_i,
  input  logic [EN_W-1:0]   cfg_deadband_i,
  input  logic [GAIN_W-1:0] cfg_gain_min_i,
  input  logic [GAIN_W-1:0] cfg_gain_max_i,
  input  logic [GAIN_W-1:0] cfg_coarse_step_i,
  input  logic [HOLD_W-1:0] cfg_holdoff_i,
  input  logic [PER_W-1:0]  cfg_period_i,
  output logic [GAIN_W-1:0] gain_o,
  output logic              coarse_act_o,
  output logic              hold_busy_o
);
  localparam int GW1 = GAIN_W + 1;

  logic [HOLD_W-1:0] hold_q;
  logic [PER_W-1:0]  per_q;
  logic [EN_W:0]     hi_lim, e_plus_db;
  logic              above, below, coarse_fire, period_end;
  gstep_e            step_sel;
  logic [GW1-1:0]    g_ext, min_ext, max_ext, step_ext;
  logic [GAIN_W-1:0] gain_d;

  always_comb begin
    hi_lim      = {1'b0, cfg_target_i} + {1'b0, cfg_deadband_i};
    e_plus_db   = {1'b0, energy_i} + {1'b0, cfg_deadband_i};
    above       = {1'b0, energy_i} > hi_lim;
    below       = e_plus_db < {1'b0, cfg_target_i};
    coarse_fire = clip_i && (hold_q == '0);
    period_end  = per_q == (cfg_period_i - PER_W'(1));
    step_sel    = GSTEP_HOLD;
    if (coarse_fire)
      step_sel = GSTEP_COARSE;
    else if (!coarse_act_o && period_end) begin
      if (above)      step_sel = GSTEP_DOWN;
      else if (below) step_sel = GSTEP_UP;
    end
  end

  always_comb begin
    g_ext    = {1'b0, gain_o};
    min_ext  = {1'b0, cfg_gain_min_i};
    max_ext  = {1'b0, cfg_gain_max_i};
    step_ext = {1'b0, cfg_coarse_step_i};
    gain_d   = gain_o;
    case (step_sel)
      GSTEP_COARSE: gain_d = (g_ext >= min_ext + step_ext) ? gain_o - cfg_coarse_step_i : cfg_gain_min_i;
      GSTEP_DOWN:   gain_d = (g_ext > min_ext) ? gain_o - GAIN_W'(1) : cfg_gain_min_i;
      GSTEP_UP:     gain_d = (g_ext < max_ext) ? gain_o + GAIN_W'(1) : cfg_gain_max_i;
      default:      gain_d = gain_o;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gain_o <= cfg_gain_max_i;
      hold_q <= '0;
      per_q  <= '0;
    end else begin
      gain_o <= gain_d;
      if (coarse_fire)        hold_q <= cfg_holdoff_i;
      else if (hold_q != '0)  hold_q <= hold_q - HOLD_W'(1);
      if (coarse_act_o || period_end) per_q <= '0;
      else                            per_q <= per_q + PER_W'(1);
    end
  end

  assign hold_busy_o  = hold_q != '0;
  assign coarse_act_o = clip_i || hold_busy_o;
endmodule

// File: rtl/agc_diag.sv
module agc_diag #(
  parameter int EN_W   = 24,
  parameter int GAIN_W = 6,
  parameter int WIN_W  = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clip_i,
  input  logic [EN_W-1:0]   energy_i,
  input  logic [GAIN_W-1:0] gain_i,
  input  logic [GAIN_W-1:0] cfg_gain_min_i,
  input  logic [EN_W-1:0]   cfg_target_i,
  input  logic [EN_W-1:0]   cfg_deadband_i,
  input  logic [WIN_W-1:0]  cfg_window_i,
  output logic [CNT_W-1:0]  clip_count_o,
  output logic [CNT_W-1:0]  sat_time_o,
  output logic [CNT_W-1:0]  desat_time_o
);
  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v, input logic en);
    if (en && (v != '1)) return v + CNT_W'(1);
    return v;
  endfunction

  logic [WIN_W-1:0] win_q;
  logic [CNT_W-1:0] clip_acc_q, sat_acc_q, dcnt_q;
  logic             drun_q, sat_now, win_end, in_band;
  logic [EN_W:0]    hi_lim, e_plus_db;

  always_comb begin
    hi_lim    = {1'b0, cfg_target_i} + {1'b0, cfg_deadband_i};
    e_plus_db = {1'b0, energy_i} + {1'b0, cfg_deadband_i};
    in_band   = ({1'b0, energy_i} <= hi_lim) && (e_plus_db >= {1'b0, cfg_target_i});
    sat_now   = gain_i == cfg_gain_min_i;
    win_end   = win_q == (cfg_window_i - WIN_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q        <= '0;
      clip_acc_q   <= '0;
      sat_acc_q    <= '0;
      clip_count_o <= '0;
      sat_time_o   <= '0;
    end else if (win_end) begin
      win_q        <= '0;
      clip_count_o <= bump(clip_acc_q, clip_i);
      sat_time_o   <= bump(sat_acc_q, sat_now);
      clip_acc_q   <= '0;
      sat_acc_q    <= '0;
    end else begin
      win_q        <= win_q + WIN_W'(1);
      clip_acc_q   <= bump(clip_acc_q, clip_i);
      sat_acc_q    <= bump(sat_acc_q, sat_now);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drun_q       <= 1'b0;
      dcnt_q       <= '0;
      desat_time_o <= '0;
    end else if (clip_i) begin
      drun_q <= 1'b1;
      dcnt_q <= CNT_W'(1);
    end else if (drun_q) begin
      if (in_band) begin
        desat_time_o <= dcnt_q;
        drun_q       <= 1'b0;
      end else begin
        dcnt_q <= bump(dcnt_q, 1'b1);
      end
    end
  end
endmodule

// File: rtl/agc_two_speed.sv
module agc_two_speed #(
  parameter  int DATA_W     = 12,
  parameter  int GAIN_W     = 6,
  parameter  int EST_SHIFT  = 4,
  parameter  int FULL_SCALE = 2047,
  parameter  int HOLD_W     = 8,
  parameter  int PER_W      = 8,
  parameter  int WIN_W      = 16,
  parameter  int CNT_W      = 16,
  localparam int EN_W       = 2 * DATA_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [DATA_W-1:0] sample_i,
  input  logic [EN_W-1:0]          cfg_target_i,
  input  logic [EN_W-1:0]          cfg_deadband_i,
  input  logic [GAIN_W-1:0]        cfg_gain_min_i,
  input  logic [GAIN_W-1:0]        cfg_gain_max_i,
  input  logic [GAIN_W-1:0]        cfg_coarse_step_i,
  input  logic [HOLD_W-1:0]        cfg_holdoff_i,
  input  logic [PER_W-1:0]         cfg_period_i,
  input  logic [WIN_W-1:0]         cfg_window_i,
  output logic [GAIN_W-1:0]        gain_o,
  output logic [EN_W-1:0]          energy_o,
  output logic [CNT_W-1:0]         clip_count_o,
  output logic [CNT_W-1:0]         sat_time_o,
  output logic [CNT_W-1:0]         desat_time_o
);
  logic clip_q, coarse_act, hold_busy;

  agc_energy_est #(
    .DATA_W(DATA_W), .EST_SHIFT(EST_SHIFT), .FULL_SCALE(FULL_SCALE)
  ) est_i (
    .clk(clk), .rst(rst), .sample_i(sample_i),
    .energy_o(energy_o), .clip_o(clip_q)
  );

  agc_gain_ctrl #(
    .EN_W(EN_W), .GAIN_W(GAIN_W), .HOLD_W(HOLD_W), .PER_W(PER_W)
  ) ctrl_i (
    .clk(clk), .rst(rst), .clip_i(clip_q), .energy_i(energy_o),
    .cfg_target_i(cfg_target_i), .cfg_deadband_i(cfg_deadband_i),
    .cfg_gain_min_i(cfg_gain_min_i), .cfg_gain_max_i(cfg_gain_max_i),
    .cfg_coarse_step_i(cfg_coarse_step_i), .cfg_holdoff_i(cfg_holdoff_i),
    .cfg_period_i(cfg_period_i), .gain_o(gain_o),
    .coarse_act_o(coarse_act), .hold_busy_o(hold_busy)
  );

  agc_diag #(
    .EN_W(EN_W), .GAIN_W(GAIN_W), .WIN_W(WIN_W), .CNT_W(CNT_W)
  ) diag_i (
    .clk(clk), .rst(rst), .clip_i(clip_q), .energy_i(energy_o),
    .gain_i(gain_o), .cfg_gain_min_i(cfg_gain_min_i),
    .cfg_target_i(cfg_target_i), .cfg_deadband_i(cfg_deadband_i),
    .cfg_window_i(cfg_window_i), .clip_count_o(clip_count_o),
    .sat_time_o(sat_time_o), .desat_time_o(desat_time_o)
  );
endmodule

// File: rtl/agc_two_speed_chk.sv
module agc_two_speed_chk #(
  parameter int GAIN_W = 6,
  parameter int WIN_W  = 16,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [GAIN_W-1:0] gain,
  input logic [GAIN_W-1:0] gmin,
  input logic [GAIN_W-1:0] gmax,
  input logic              coarse_act,
  input logic              hold_busy,
  input logic [CNT_W-1:0]  clip_count,
  input logic [CNT_W-1:0]  sat_time,
  input logic [WIN_W-1:0]  window
);
  p_gain_in_range_r6: assert property (@(posedge clk) disable iff (rst)
    (gain >= gmin) && (gain <= gmax));

  p_holdoff_freeze_r3: assert property (@(posedge clk) disable iff (rst)
    hold_busy |=> $stable(gain));

  p_coarse_no_rise_r4: assert property (@(posedge clk) disable iff (rst)
    coarse_act |=> (gain <= $past(gain)));

  p_fine_unit_step_r5: assert property (@(posedge clk) disable iff (rst)
    !coarse_act |=> ((gain == $past(gain)) || (gain == $past(gain) + GAIN_W'(1))
                     || (gain == $past(gain) - GAIN_W'(1))));

  p_clip_count_bound_r7: assert property (@(posedge clk) disable iff (rst)
    32'(clip_count) <= 32'(window));

  p_sat_time_bound_r8: assert property (@(posedge clk) disable iff (rst)
    32'(sat_time) <= 32'(window));
endmodule

bind agc_two_speed agc_two_speed_chk #(
  .GAIN_W(GAIN_W), .WIN_W(WIN_W), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst(rst), .gain(gain_o), .gmin(cfg_gain_min_i),
  .gmax(cfg_gain_max_i), .coarse_act(coarse_act), .hold_busy(hold_busy),
  .clip_count(clip_count_o), .sat_time(sat_time_o), .window(cfg_window_i)
);

// File: tb/agc_two_speed_tb_top.sv
`timescale 1ns/1ps
module agc_two_speed_tb_top;
  localparam int DATA_W = 12, GAIN_W = 6, SHIFT = 4, FS = 2047;
  localparam int EN_W = 2 * DATA_W;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [DATA_W-1:0] sample = '0;
  always #2.5 clk = ~clk;

  int c_target = 250000, c_db = 50000, c_min = 4, c_max = 60;
  int c_step = 8, c_hold = 16, c_period = 32, c_window = 256;

  logic [GAIN_W-1:0] gain_o;
  logic [EN_W-1:0]   energy_o;
  logic [15:0]       clip_count_o, sat_time_o, desat_time_o;

  agc_two_speed dut_i (
    .clk(clk), .rst(rst), .sample_i(sample),
    .cfg_target_i(EN_W'(c_target)), .cfg_deadband_i(EN_W'(c_db)),
    .cfg_gain_min_i(GAIN_W'(c_min)), .cfg_gain_max_i(GAIN_W'(c_max)),
    .cfg_coarse_step_i(GAIN_W'(c_step)), .cfg_holdoff_i(8'(c_hold)),
    .cfg_period_i(8'(c_period)), .cfg_window_i(16'(c_window)),
    .gain_o(gain_o), .energy_o(energy_o), .clip_count_o(clip_count_o),
    .sat_time_o(sat_time_o), .desat_time_o(desat_time_o)
  );

  int n_checks = 0, n_err = 0, cyc = 0;

  // reference state
  longint m_acc;
  int m_clip, m_gain, m_hold, m_per, m_win, m_cacc, m_sacc, m_cout, m_sout;
  int m_drun, m_dcnt, m_dout;

  always @(posedge clk) begin
    longint e;
    int x, ng, nh, np;
    bit inband, satnow;
    x = int'(sample);
    if (rst) begin
      m_acc = 0; m_clip = 0; m_gain = c_max; m_hold = 0; m_per = 0;
      m_win = 0; m_cacc = 0; m_sacc = 0; m_cout = 0; m_sout = 0;
      m_drun = 0; m_dcnt = 0; m_dout = 0;
    end else begin
      e = m_acc >>> SHIFT;
      ng = m_gain; nh = m_hold; np = m_per + 1;
      if (m_clip != 0 && m_hold == 0) begin
        ng = (m_gain - c_step < c_min) ? c_min : m_gain - c_step;
        nh = c_hold; np = 0;
      end else if (m_hold != 0 || m_clip != 0) begin
        nh = (m_hold > 0) ? m_hold - 1 : 0; np = 0;
      end else if (m_per == c_period - 1) begin
        np = 0;
        if (e > c_target + c_db)       ng = (m_gain > c_min) ? m_gain - 1 : c_min;
        else if (e + c_db < c_target)  ng = (m_gain < c_max) ? m_gain + 1 : c_max;
      end
      satnow = (m_gain == c_min);
      if (m_win == c_window - 1) begin
        m_cout = m_cacc + m_clip; m_sout = m_sacc + int'(satnow);
        m_cacc = 0; m_sacc = 0; m_win = 0;
      end else begin
        m_cacc += m_clip; m_sacc += int'(satnow); m_win++;
      end
      inband = (e <= c_target + c_db) && (e + c_db >= c_target);
      if (m_clip != 0) begin m_drun = 1; m_dcnt = 1; end
      else if (m_drun != 0) begin
        if (inband) begin m_dout = m_dcnt; m_drun = 0; end
        else if (m_dcnt < 65535) m_dcnt++;
      end
      m_gain = ng; m_hold = nh; m_per = np;
      m_acc = m_acc - (m_acc >>> SHIFT) + longint'(x) * longint'(x);
      m_clip = ((x < 0 ? -x : x) >= FS) ? 1 : 0;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic compare_all();
    chk("gain R3 R4 R5 R6", gain_o, m_gain);
    chk("energy R1", energy_o, m_acc >>> SHIFT);
    chk("clip count R2 R7", clip_count_o, m_cout);
    chk("floor time R8", sat_time_o, m_sout);
    chk("recovery R9", desat_time_o, m_dout);
  endtask

  task automatic drive(input int v);
    @(negedge clk);
    compare_all();
    sample = DATA_W'(v);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      n_err++;
      $display("FAIL R10 watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    repeat (4) drive(0);
    @(negedge clk);
    // R10: reset state
    chk("reset gain R10", gain_o, c_max);
    chk("reset energy R10", energy_o, 0);
    chk("reset clip count R10", clip_count_o, 0);
    chk("reset floor time R10", sat_time_o, 0);
    chk("reset recovery R10", desat_time_o, 0);
    rst = 1'b0;
    // quiet input: gain pinned at ceiling (R6, R5 up)
    for (int i = 0; i < 600; i++) drive((i % 2) ? 100 : -100);
    @(negedge clk); chk("ceiling hold R6", gain_o, c_max);
    // strong in-range input: slow loop walks gain down (R5)
    for (int i = 0; i < 1000; i++) drive((i % 2) ? 1000 : -1000);
    @(negedge clk); chk("slow trim down R5", (gain_o < GAIN_W'(c_max)) ? 1 : 0, 1);
    // full-scale burst: fast steps to floor (R2, R3, R6)
    for (int i = 0; i < 200; i++) drive((i % 2) ? 2047 : -2048);
    @(negedge clk); chk("floor reached R3 R6", gain_o, c_min);
    // in-band input: recovery measured (R9) and floor time logged (R8)
    for (int i = 0; i < 300; i++) drive((i % 2) ? 500 : -500);
    @(negedge clk);
    chk("recovery nonzero R9", (desat_time_o != 0) ? 1 : 0, 1);
    chk("floor time nonzero R8", (sat_time_o != 0) ? 1 : 0, 1);
    chk("clip count nonzero R7", (clip_count_o != 0) ? 1 : 0, 1);
    // quiet again: slow loop raises gain (R5)
    for (int i = 0; i < 400; i++) drive((i % 2) ? 100 : -100);
    @(negedge clk); chk("slow trim up R5", (gain_o > GAIN_W'(c_min)) ? 1 : 0, 1);
    // random mix with sparse clips (R1..R9 via per-cycle compare)
    for (int i = 0; i < 5000; i++) begin
      int r;
      r = int'($urandom_range(0, 199));
      if (r == 0)      drive(2047);
      else if (r == 1) drive(-2048);
      else if (r == 2) drive(2046);
      else             drive(int'($urandom_range(0, 1400)) - 700);
    end
    drive(0);
    finish_run();
  end
endmodule